// File: doc/BRIEF.md
# Deficit Round Robin Packet Scheduler

This block chooses which of several packet queues sends its next packet onto a shared link, so that over time each queue receives link bytes in proportion to a byte quantum set for that queue. The queues themselves live outside the block. Each queue reports whether it holds a packet and the byte length of the packet at its head. The scheduler answers with a grant that names the queue and carries that packet's length. The grant uses a valid/ready handshake toward the link side.

The scheduler visits queues in a fixed cyclic order. When a visit starts on a queue that holds packets, that queue's quantum is added to its private byte credit. Head packets are then granted one per cycle for as long as the credit covers the head length, and each grant lowers the credit by that length. The visit ends when the credit no longer covers the head packet, and the remaining credit is kept for the next visit. It also ends when the queue runs dry, and the credit is then cleared. Quantum registers can be rewritten at any time through a simple write port.

Top module: `drr_sched`

## Requirements
- R1: Reset clears every credit counter, sets every quantum to the parameter QNT_RST (64 by default), holds grant_valid low and starts the round at queue 0. With all queues loaded, the first grant therefore goes to queue 0.
- R2: Queues are visited in increasing index order, wrapping from the last index to 0. A visit to an empty queue adds no credit and takes one clock cycle.
- R3: A visit to a non-empty queue adds its quantum to its credit exactly once. The credit register is one bit wider than the wider of quantum and length, so the sum never wraps.
- R4: During a visit the head packet is granted when its credit is greater than or equal to the head length (equality is enough), and the length is then subtracted from the credit.
- R5: A visit ends and the pointer moves on when the credit falls below the head length. The remaining credit is kept for that queue's next visit.
- R6: When a queue runs empty during its visit, its credit is cleared to zero, so that queue starts its next busy period with no leftover credit.
- R7: Each queue has its own quantum. A quantum written through the write port (qnt_wr_idx selects the queue) takes effect at that queue's next credit addition and does not change a visit already under way.
- R8: At most one grant completes per clock, only on a cycle where grant_ready is high. A stalled grant keeps grant_valid, grant_idx and grant_len steady until it is accepted. The head length presented in the cycle after a grant is the one used for the next comparison.
- R9: When no queue holds a packet, grant_valid stays low and the pointer and all credits hold.
- R10: The first grant of a visit is offered one clock edge after the visit starts, since the credit is added on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | N_Q | Bit i is high when queue i holds a packet |
| q_head_len | input | N_Q*LEN_W | Head packet byte length of queue i in bits [i*LEN_W +: LEN_W] |
| qnt_wr_en | input | 1 | Quantum write strobe |
| qnt_wr_idx | input | IDX_W | Queue whose quantum is written |
| qnt_wr_val | input | QNT_W | New quantum in bytes |
| grant_valid | output | 1 | A grant is offered |
| grant_ready | input | 1 | The link side accepts the grant |
| grant_idx | output | IDX_W | Granted queue |
| grant_len | output | LEN_W | Byte length of the granted packet |

## Verification
A grant is due one edge after its visit begins. Each empty queue the pointer passes costs one edge. After an accepted grant, the next decision on the same queue uses the head presented in the following cycle. The bench drives all inputs at the falling edge and samples the outputs 1 ns later, so each check falls in the cycle where these counts put the result. The timing checks count edges from a queue load up to the first offer. The sweeps compare the sequence of accepted grants against a byte-credit model kept in the bench. That comparison holds whatever the ready pattern, so the sweeps can stall grants freely.

// File: rtl/drr_pkg.sv
`timescale 1ns/1ps
package drr_pkg;
  // Scheduler phase: choose the next queue, or serve the chosen one
  typedef enum logic {
    PH_PICK  = 1'b0,
    PH_SERVE = 1'b1
  } drr_phase_e;
endpackage

// File: rtl/drr_qnt_regs.sv
`timescale 1ns/1ps
module drr_qnt_regs #(
  parameter int N_Q     = 4,
  parameter int QNT_W   = 8,
  parameter int QNT_RST = 64,
  parameter int IDX_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [QNT_W-1:0]       wr_val,
  output logic [N_Q*QNT_W-1:0]   qnt_flat
);
  for (genvar g = 0; g < N_Q; g++) begin : g_qnt
    logic [QNT_W-1:0] qnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        qnt_q <= QNT_W'(QNT_RST);
      else if (wr_en && (wr_idx == IDX_W'(g)))
        qnt_q <= wr_val;
    end
    assign qnt_flat[g*QNT_W +: QNT_W] = qnt_q;
  end
endmodule

// File: rtl/drr_deficit_bank.sv
`timescale 1ns/1ps
module drr_deficit_bank #(
  parameter int N_Q   = 4,
  parameter int QNT_W = 8,
  parameter int LEN_W = 8,
  parameter int IDX_W = 2,
  parameter int DC_W  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     sel,
  input  logic                 credit_en,
  input  logic                 debit_en,
  input  logic                 clr_en,
  input  logic [N_Q*QNT_W-1:0] qnt_flat,
  input  logic [LEN_W-1:0]     debit_len,
  output logic [DC_W-1:0]      dc_sel
);
  // Credit arithmetic, kept in functions
  function automatic logic [DC_W-1:0] add_credit(input logic [DC_W-1:0] dc,
                                                  input logic [QNT_W-1:0] q);
    return dc + DC_W'(q);
  endfunction

  function automatic logic [DC_W-1:0] take_debit(input logic [DC_W-1:0] dc,
                                                  input logic [LEN_W-1:0] len);
    return dc - DC_W'(len);
  endfunction

  logic [DC_W-1:0] dc_q [N_Q];

  for (genvar g = 0; g < N_Q; g++) begin : g_dc
    logic hit;
    assign hit = (sel == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        dc_q[g] <= '0;
      else if (hit && clr_en)
        dc_q[g] <= '0;
      else if (hit && credit_en)
        dc_q[g] <= add_credit(dc_q[g], qnt_flat[g*QNT_W +: QNT_W]);
      else if (hit && debit_en)
        dc_q[g] <= take_debit(dc_q[g], debit_len);
    end
  end

  assign dc_sel = dc_q[sel];

  // R3: credit entering an addition is always below the largest length,
  // which together with DC_W keeps the sum from wrapping
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    credit_en |-> (dc_sel < DC_W'((2**LEN_W) - 1)));

  // R6: a queue that ran dry holds zero credit afterwards
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (dc_q[$past(sel)] == '0));
endmodule

// File: rtl/drr_rr_ctrl.sv
`timescale 1ns/1ps
module drr_rr_ctrl
  import drr_pkg::*;
#(
  parameter int N_Q   = 4,
  parameter int LEN_W = 8,
  parameter int IDX_W = 2,
  parameter int DC_W  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_Q-1:0]       q_ne,
  input  logic [N_Q*LEN_W-1:0] head_len_flat,
  input  logic [DC_W-1:0]      dc_sel,
  input  logic                 out_ready,
  output logic [IDX_W-1:0]     ptr,
  output logic [LEN_W-1:0]     cur_len,
  output logic                 credit_ev,
  output logic                 debit_ev,
  output logic                 clr_ev,
  output logic                 grant_valid
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N_Q - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic fits(input logic [DC_W-1:0] dc,
                                input logic [LEN_W-1:0] len);
    return dc >= DC_W'(len);
  endfunction

  drr_phase_e       phase_q, phase_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             any_ne, cur_ne;

  assign any_ne  = |q_ne;
  assign cur_ne  = q_ne[ptr_q];
  assign cur_len = head_len_flat[ptr_q*LEN_W +: LEN_W];
  assign ptr     = ptr_q;

  always_comb begin
    phase_d     = phase_q;
    ptr_d       = ptr_q;
    credit_ev   = 1'b0;
    debit_ev    = 1'b0;
    clr_ev      = 1'b0;
    grant_valid = 1'b0;
    unique case (phase_q)
      PH_PICK: begin
        if (any_ne) begin
          if (cur_ne) begin
            credit_ev = 1'b1;
            phase_d   = PH_SERVE;
          end else begin
            ptr_d = step(ptr_q);
          end
        end
      end
      PH_SERVE: begin
        if (!cur_ne) begin
          clr_ev  = 1'b1;
          ptr_d   = step(ptr_q);
          phase_d = PH_PICK;
        end else if (fits(dc_sel, cur_len)) begin
          grant_valid = 1'b1;
          debit_ev    = out_ready;
        end else begin
          ptr_d   = step(ptr_q);
          phase_d = PH_PICK;
        end
      end
      default: phase_d = PH_PICK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_PICK;
      ptr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      ptr_q   <= ptr_d;
    end
  end

  // R3: credit is added once per visit, never on two cycles in a row
  p_one_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ev |=> !credit_ev);

  // R2: an empty queue met while choosing is passed over in one cycle
  p_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PICK && any_ne && !cur_ne) |=> (ptr_q == step($past(ptr_q))));

  // R9: no packets anywhere means no grant
  p_idle_nogrant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ne |-> !grant_valid);

  // R9: the round pointer holds while all queues are empty
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PICK && !any_ne) |=> $stable(ptr_q));
endmodule

// File: rtl/drr_sched.sv
`timescale 1ns/1ps
module drr_sched #(
  parameter int N_Q     = 4,
  parameter int LEN_W   = 8,
  parameter int QNT_W   = 8,
  parameter int QNT_RST = 64,
  localparam int IDX_W  = (N_Q > 1) ? $clog2(N_Q) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_Q-1:0]       q_nonempty,
  input  logic [N_Q*LEN_W-1:0] q_head_len,
  input  logic                 qnt_wr_en,
  input  logic [IDX_W-1:0]     qnt_wr_idx,
  input  logic [QNT_W-1:0]     qnt_wr_val,
  output logic                 grant_valid,
  input  logic                 grant_ready,
  output logic [IDX_W-1:0]     grant_idx,
  output logic [LEN_W-1:0]     grant_len
);
  localparam int DC_W = ((QNT_W > LEN_W) ? QNT_W : LEN_W) + 1;

  // Internal events, named for the assertions
  logic [N_Q*QNT_W-1:0] qnt_flat;
  logic [DC_W-1:0]      dc_sel;
  logic [IDX_W-1:0]     ptr;
  logic [LEN_W-1:0]     cur_len;
  logic                 credit_ev, debit_ev, clr_ev;

  drr_qnt_regs #(
    .N_Q(N_Q), .QNT_W(QNT_W), .QNT_RST(QNT_RST), .IDX_W(IDX_W)
  ) u_qnt (
    .clk(clk), .rst_n(rst_n), .wr_en(qnt_wr_en), .wr_idx(qnt_wr_idx),
    .wr_val(qnt_wr_val), .qnt_flat(qnt_flat)
  );

  drr_deficit_bank #(
    .N_Q(N_Q), .QNT_W(QNT_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .DC_W(DC_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .sel(ptr), .credit_en(credit_ev),
    .debit_en(debit_ev), .clr_en(clr_ev), .qnt_flat(qnt_flat),
    .debit_len(cur_len), .dc_sel(dc_sel)
  );

  drr_rr_ctrl #(
    .N_Q(N_Q), .LEN_W(LEN_W), .IDX_W(IDX_W), .DC_W(DC_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .q_ne(q_nonempty), .head_len_flat(q_head_len),
    .dc_sel(dc_sel), .out_ready(grant_ready), .ptr(ptr), .cur_len(cur_len),
    .credit_ev(credit_ev), .debit_ev(debit_ev), .clr_ev(clr_ev),
    .grant_valid(grant_valid)
  );

  assign grant_idx = ptr;
  assign grant_len = cur_len;

  // R8: an offered grant that is not taken stays offered and unchanged
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=>
      (grant_valid && $stable(grant_idx) && $stable(grant_len)));

  // R8: credit is spent only on an accepted grant
  p_debit_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    debit_ev |-> (grant_valid && grant_ready));
endmodule

// File: tb/test_drr_sched.sv
`timescale 1ns/1ps
module test_drr_sched;
  localparam int NQ = 4, LW = 8, QW = 8, QRST = 64, MAXP = 8, MAXE = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NQ-1:0]   q_nonempty;
  logic [NQ*LW-1:0] q_head_len;
  logic            qnt_wr_en;
  logic [1:0]      qnt_wr_idx;
  logic [QW-1:0]   qnt_wr_val;
  logic            grant_valid, grant_ready;
  logic [1:0]      grant_idx;
  logic [LW-1:0]   grant_len;

  always #2.5 clk = ~clk;

  drr_sched #(.N_Q(NQ), .LEN_W(LW), .QNT_W(QW), .QNT_RST(QRST)) i_drr_sched (
    .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_head_len(q_head_len),
    .qnt_wr_en(qnt_wr_en), .qnt_wr_idx(qnt_wr_idx), .qnt_wr_val(qnt_wr_val),
    .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_idx(grant_idx), .grant_len(grant_len));

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Queue model driving the inputs
  int m_pk [NQ][MAXP];
  int m_hd [NQ];
  int m_cnt[NQ];
  // Credit model
  int g_dc[NQ], g_q[NQ], g_ptr;
  int e_idx[MAXE], e_len[MAXE], e_n;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int q = 0; q < NQ; q++) begin
      q_nonempty[q] = (m_cnt[q] > 0);
      q_head_len[q*LW +: LW] = (m_cnt[q] > 0) ? LW'(m_pk[q][m_hd[q]]) : '0;
    end
  endtask

  task automatic push(input int q, input int len);
    m_pk[q][m_hd[q] + m_cnt[q]] = len;
    m_cnt[q]++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; qnt_wr_en = 1'b0; grant_ready = 1'b0;
    qnt_wr_idx = '0; qnt_wr_val = '0;
    for (int q = 0; q < NQ; q++) begin
      m_hd[q] = 0; m_cnt[q] = 0; g_dc[q] = 0; g_q[q] = QRST;
    end
    g_ptr = 0;
    drive();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(grant_valid == 1'b0, "R1", "grant_valid after reset", grant_valid, 0);
  endtask

  task automatic write_qnt(input int q, input int v);
    @(negedge clk);
    qnt_wr_en = 1'b1; qnt_wr_idx = 2'(q); qnt_wr_val = QW'(v);
    @(negedge clk);
    qnt_wr_en = 1'b0;
    g_q[q] = v;
  endtask

  // Byte-credit model of the whole drain; state persists between calls
  task automatic predict(input int chg_q, input int chg_val);
    int hd[NQ], cnt[NQ];
    bit applied = 1'b0;
    bit any;
    e_n = 0;
    for (int q = 0; q < NQ; q++) begin hd[q] = m_hd[q]; cnt[q] = m_cnt[q]; end
    any = 1'b0;
    for (int q = 0; q < NQ; q++) if (cnt[q] > 0) any = 1'b1;
    while (any) begin
      int i = g_ptr;
      if (cnt[i] > 0) begin
        bit granted = 1'b0;
        g_dc[i] += g_q[i];
        while (cnt[i] > 0 && g_dc[i] >= m_pk[i][hd[i]]) begin
          e_idx[e_n] = i; e_len[e_n] = m_pk[i][hd[i]]; e_n++;
          g_dc[i] -= m_pk[i][hd[i]];
          hd[i]++; cnt[i]--; granted = 1'b1;
        end
        if (cnt[i] == 0) g_dc[i] = 0;
        if (i == chg_q && granted && !applied) begin
          g_q[i] = chg_val; applied = 1'b1;
        end
      end
      g_ptr = (g_ptr + 1) % NQ;
      any = 1'b0;
      for (int q = 0; q < NQ; q++) if (cnt[q] > 0) any = 1'b1;
    end
  endtask

  // Drain the loaded queues and compare the accepted grant sequence
  task automatic run(input int mode, input int chg_q, input int chg_val,
                     input string req);
    int got = 0, idle = 0, hs_q = -1;
    bit wr_done = 1'b0;
    predict(chg_q, chg_val);
    for (int t = 0; t < 6000 && idle < 8; t++) begin
      bit empty;
      @(negedge clk);
      qnt_wr_en = 1'b0;
      if (hs_q >= 0) begin m_hd[hs_q]++; m_cnt[hs_q]--; hs_q = -1; end
      drive();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      grant_ready = (mode == 0) ? 1'b1 : (mode == 1) ? 1'(t % 2) : lfsr[0];
      #1;
      if (grant_valid && grant_ready) begin
        if (got < e_n) begin
          chk(int'(grant_idx) == e_idx[got], req, "grant queue", grant_idx, e_idx[got]);
          chk(int'(grant_len) == e_len[got], req, "grant length", grant_len, e_len[got]);
        end else begin
          chk(1'b0, req, "extra grant index", got, e_n);
        end
        got++;
        hs_q = grant_idx;
        if (chg_q == int'(grant_idx) && !wr_done) begin
          qnt_wr_en = 1'b1; qnt_wr_idx = grant_idx; qnt_wr_val = QW'(chg_val);
          wr_done = 1'b1;
        end
      end
      empty = 1'b1;
      for (int q = 0; q < NQ; q++) if (m_cnt[q] > 0) empty = 1'b0;
      if (empty && hs_q < 0) idle++;
    end
    chk(got == e_n, req, "grant count", got, e_n);
    chk(grant_valid == 1'b0, "R9", "grant_valid with all queues empty", grant_valid, 0);
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; q_nonempty = '0; q_head_len = '0;
    qnt_wr_en = 1'b0; qnt_wr_idx = '0; qnt_wr_val = '0; grant_ready = 1'b0;

    // R9: idle scheduler offers nothing
    do_reset();
    repeat (20) @(negedge clk);
    #1 chk(grant_valid == 1'b0, "R9", "idle grant_valid", grant_valid, 0);

    // R10 / R1: queue 0 loaded, offer one edge later
    do_reset();
    @(negedge clk);
    push(0, 10); push(1, 12); drive(); grant_ready = 1'b0;
    #1 chk(grant_valid == 1'b0, "R10", "offer before credit edge", grant_valid, 0);
    @(negedge clk);
    #1 chk(grant_valid == 1'b1, "R10", "offer one edge after visit", grant_valid, 1);
    chk(grant_idx == 2'd0, "R1", "first queue served", grant_idx, 0);
    chk(grant_len == 8'd10, "R10", "offered length", grant_len, 10);
    run(0, -1, 0, "R1");

    // R2: only queue 2 loaded, two skips then credit
    do_reset();
    @(negedge clk);
    push(2, 30); drive();
    @(negedge clk);
    @(negedge clk);
    #1 chk(grant_valid == 1'b0, "R2", "offer after two skips", grant_valid, 0);
    @(negedge clk);
    #1 chk(grant_valid == 1'b1, "R2", "offer after credit edge", grant_valid, 1);
    chk(grant_idx == 2'd2, "R2", "skipped to queue", grant_idx, 2);
    run(0, -1, 0, "R2");

    // R4 / R5: equal credit suffices, leftover carried
    do_reset();
    write_qnt(0, 40);
    push(0, 40); push(0, 41); push(1, 5);
    run(0, -1, 0, "R4_R5");

    // R6: credit cleared when queue 1 runs dry, visible in the next busy period
    do_reset();
    write_qnt(0, 20); write_qnt(1, 100); write_qnt(2, 20); write_qnt(3, 20);
    push(1, 10);
    run(0, -1, 0, "R6");
    write_qnt(1, 20);
    push(1, 60); push(2, 50);
    run(0, -1, 0, "R6");

    // R7: quantum rewritten mid-visit applies from the next visit
    do_reset();
    write_qnt(0, 16); write_qnt(1, 16);
    for (int k = 0; k < 4; k++) begin push(0, 8); push(1, 8); end
    run(1, 0, 8, "R7");

    // R3 / R7 / R8: sweep of quanta, loads and ready patterns
    for (int seed = 0; seed < 6; seed++) begin
      for (int mode = 0; mode < 3; mode++) begin
        do_reset();
        for (int q = 0; q < NQ; q++) write_qnt(q, 8 + ((seed * 23 + q * 17) % 100));
        for (int q = 0; q < NQ; q++)
          for (int k = 0; k < (seed + 2 * q) % 6; k++)
            push(q, 1 + ((seed * 13 + q * 31 + k * 47) % 120));
        run(mode, -1, 0, "R3_R8");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule